// File: doc/BRIEF.md
# Extended Multiply and Divide Unit

This block is a sequential arithmetic engine that works on three 16-bit working registers, called D, X and Y. It performs four operations: a signed 16/16 divide, an unsigned 32/16 divide, a signed 32/16 divide and a signed 16x16 multiply. A surrounding execution pipeline pulses `start` with an operation code and the current register values. Some cycles later it receives a one-cycle `done` pulse. With that pulse come the new register values, one write enable per register, and new N, Z, V and C condition flags. A per-flag update mask says which flags the operation defines.

Division uses a restoring shift-subtract core that produces one quotient bit per cycle over a full 32-bit quotient, so quotient overflow is known exactly. Multiplication uses a shift-add core that consumes one multiplier bit per cycle. Signed operations run on magnitudes, and the sign is fixed up when the result is written. Each operation has a fixed latency that does not depend on its operands.

Top module: `wide_arith_unit`

## Requirements
- R1: Operation code 0 (signed 16/16) divides D by X, both two's complement. The quotient, truncated toward zero, is written to X. The remainder is written to D and takes the sign of the dividend.
- R2: Operation code 1 (unsigned 32/16) divides the 32-bit value Y:D (Y is the high half) by X. The low 16 bits of the quotient go to Y and the remainder goes to D.
- R3: Operation code 2 (signed 32/16) uses the same register pairing as code 1, with dividend and divisor in two's complement. It truncates toward zero, and the remainder takes the sign of the dividend.
- R4: Operation code 3 (signed multiply) forms the 32-bit signed product of D and Y. The low half goes to D and the high half to Y.
- R5: A divide whose divisor X is zero asserts no write enable, drives C to 1 and sets the flag mask to 4'b0001.
- R6: A divide with a nonzero divisor sets the mask to 4'b1111 and clears C. The mask bit order is bit 3 N, bit 2 Z, bit 1 V, bit 0 C. N is bit 15 of the written quotient, and Z is set when the full quotient is zero. V is set when the quotient exceeds 0xFFFF for code 1, or lies outside -32768..32767 for codes 0 and 2.
- R7: A multiply sets the mask to 4'b1101 (V is not updated). N is product bit 31, Z is set when the 32-bit product is zero, and C is product bit 15.
- R8: If `start` is accepted at rising edge k, `done` is high for exactly the one cycle after edge k+34 for a divide, or edge k+18 for a multiply.
- R9: `busy` is high from the cycle after acceptance up to, but not including, the `done` cycle. A `start` seen while `busy` is high is ignored, and a `start` in the `done` cycle is accepted.
- R10: Write enables are high only in the `done` cycle. In that cycle, each register output that is not written shows the value captured at `start`. After reset, `busy`, `done` and all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled while idle |
| op | input | 2 | Operation code (0..3, see R1-R4) |
| d_in | input | 16 | Current D register |
| x_in | input | 16 | Current X register |
| y_in | input | 16 | Current Y register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| d_out | output | 16 | New D value |
| x_out | output | 16 | New X value |
| y_out | output | 16 | New Y value |
| d_we | output | 1 | Write D |
| x_we | output | 1 | Write X |
| y_we | output | 1 | Write Y |
| flag_n | output | 1 | New N flag |
| flag_z | output | 1 | New Z flag |
| flag_v | output | 1 | New V flag |
| flag_c | output | 1 | New C flag |
| flag_mask | output | 4 | Flags to update: {N, Z, V, C} |

## Verification
The assertions assume `op`, `d_in`, `x_in` and `y_in` hold stable in any cycle where `start` is high while the unit is idle. They do not assume that `start` stays low while the unit is busy. The latency and pulse-width properties count cycles from the accepting edge, and the divide-by-zero and mask properties refer to the operation and divisor captured there. The stimulus drives all inputs on falling edges, so captured values are never ambiguous. It deliberately pulses `start` with different operands in the middle of an operation, and issues each new request in the `done` cycle of the previous one.

// File: rtl/wau_pkg.sv
package wau_pkg;

    typedef enum logic [1:0] {
        OP_SDIV16 = 2'd0,
        OP_UDIV32 = 2'd1,
        OP_SDIV32 = 2'd2,
        OP_SMUL16 = 2'd3
    } wau_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_WAIT  = 2'd2
    } wau_state_e;

    // flag vector bit positions
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;

endpackage

// File: rtl/wau_div_core.sv
// Restoring shift-subtract divider: one quotient bit per cycle.
module wau_div_core #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic [DEN_W-1:0] rem,
    output logic             valid
);
    localparam int CW = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             run;
        logic             vld;
        logic [CW-1:0]    cnt;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] rem;
        logic [DEN_W-1:0] den;
    } div_st_t;

    div_st_t    cur_q, nxt_d;
    logic [DEN_W:0] shifted_d;
    logic [DEN_W:0] diff_d;
    logic           ge_d;

    always_comb begin
        shifted_d = {cur_q.rem, cur_q.quo[NUM_W-1]};
        ge_d      = shifted_d >= {1'b0, cur_q.den};
        diff_d    = shifted_d - {1'b0, cur_q.den};
        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        if (load) begin
            nxt_d.run = 1'b1;
            nxt_d.cnt = CW'(NUM_W);
            nxt_d.quo = num;
            nxt_d.rem = '0;
            nxt_d.den = den;
        end else if (cur_q.run) begin
            nxt_d.rem = ge_d ? diff_d[DEN_W-1:0] : shifted_d[DEN_W-1:0];
            nxt_d.quo = {cur_q.quo[NUM_W-2:0], ge_d};
            nxt_d.cnt = cur_q.cnt - CW'(1);
            if (cur_q.cnt == CW'(1)) begin
                nxt_d.run = 1'b0;
                nxt_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign quo   = cur_q.quo;
    assign rem   = cur_q.rem;
    assign valid = cur_q.vld;

endmodule

// File: rtl/wau_mul_core.sv
// Shift-add multiplier on unsigned magnitudes: one multiplier bit per cycle.
module wau_mul_core #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod,
    output logic           valid
);
    localparam int PW = 2 * W;
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          run;
        logic          vld;
        logic [CW-1:0] cnt;
        logic [PW-1:0] acc;
        logic [PW-1:0] mcand;
        logic [W-1:0]  mplier;
    } mul_st_t;

    mul_st_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        if (load) begin
            nxt_d.run    = 1'b1;
            nxt_d.cnt    = CW'(W);
            nxt_d.acc    = '0;
            nxt_d.mcand  = {{W{1'b0}}, a};
            nxt_d.mplier = b;
        end else if (cur_q.run) begin
            if (cur_q.mplier[0]) nxt_d.acc = cur_q.acc + cur_q.mcand;
            nxt_d.mcand  = {cur_q.mcand[PW-2:0], 1'b0};
            nxt_d.mplier = {1'b0, cur_q.mplier[W-1:1]};
            nxt_d.cnt    = cur_q.cnt - CW'(1);
            if (cur_q.cnt == CW'(1)) begin
                nxt_d.run = 1'b0;
                nxt_d.vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign prod  = cur_q.acc;
    assign valid = cur_q.vld;

endmodule

// File: rtl/wide_arith_unit.sv
module wide_arith_unit
    import wau_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] d_in,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] d_out,
    output logic [W-1:0] x_out,
    output logic [W-1:0] y_out,
    output logic         d_we,
    output logic         x_we,
    output logic         y_we,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_v,
    output logic         flag_c,
    output logic [3:0]   flag_mask
);
    localparam int W2 = 2 * W;
    // quotient magnitude limits for the signed forms
    localparam logic [W2-1:0] QPOS_MAX = {{(W2-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic [W2-1:0] QNEG_MAX = {{(W2-W){1'b0}}, 1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        wau_state_e   st;
        wau_op_e      op;
        logic [W-1:0] d;
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic         done;
        logic [W-1:0] dout;
        logic [W-1:0] xout;
        logic [W-1:0] yout;
        logic         dwe;
        logic         xwe;
        logic         ywe;
        logic [3:0]   flags;
        logic [3:0]   mask;
    } top_st_t;

    top_st_t cur_q, nxt_d;

    // operand preparation
    logic          is_div_d;
    logic [W2-1:0] dvd_raw_d;
    logic          dvd_neg_d;
    logic          dvs_neg_d;
    logic          quo_neg_d;
    logic [W2-1:0] dvd_mag_d;
    logic [W-1:0]  dvs_mag_d;
    logic [W-1:0]  ma_mag_d;
    logic [W-1:0]  mb_mag_d;
    logic          prod_neg_d;

    // core handshake
    logic          div_load_d, mul_load_d;
    logic [W2-1:0] div_quo;
    logic [W-1:0]  div_rem;
    logic          div_vld;
    logic [W2-1:0] mul_prod;
    logic          mul_vld;

    // result fix-up
    logic [W-1:0]  quo_lo_d;
    logic [W-1:0]  rem_s_d;
    logic          div_ovf_d;
    logic [W2-1:0] prod_s_d;

    always_comb begin
        is_div_d  = cur_q.op != OP_SMUL16;
        dvd_raw_d = (cur_q.op == OP_SDIV16) ? {{W{cur_q.d[W-1]}}, cur_q.d}
                                            : {cur_q.y, cur_q.d};
        unique case (cur_q.op)
            OP_SDIV16: dvd_neg_d = cur_q.d[W-1];
            OP_SDIV32: dvd_neg_d = cur_q.y[W-1];
            default:   dvd_neg_d = 1'b0;
        endcase
        dvs_neg_d  = (cur_q.op != OP_UDIV32) && cur_q.x[W-1];
        quo_neg_d  = dvd_neg_d ^ dvs_neg_d;
        dvd_mag_d  = dvd_neg_d ? (~dvd_raw_d + W2'(1)) : dvd_raw_d;
        dvs_mag_d  = dvs_neg_d ? (~cur_q.x + W'(1)) : cur_q.x;
        ma_mag_d   = cur_q.d[W-1] ? (~cur_q.d + W'(1)) : cur_q.d;
        mb_mag_d   = cur_q.y[W-1] ? (~cur_q.y + W'(1)) : cur_q.y;
        prod_neg_d = cur_q.d[W-1] ^ cur_q.y[W-1];
    end

    always_comb begin
        quo_lo_d = quo_neg_d ? (~div_quo[W-1:0] + W'(1)) : div_quo[W-1:0];
        rem_s_d  = dvd_neg_d ? (~div_rem + W'(1)) : div_rem;
        if (cur_q.op == OP_UDIV32)
            div_ovf_d = |div_quo[W2-1:W];
        else if (quo_neg_d)
            div_ovf_d = div_quo > QNEG_MAX;
        else
            div_ovf_d = div_quo > QPOS_MAX;
        prod_s_d = prod_neg_d ? (~mul_prod + W2'(1)) : mul_prod;
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        nxt_d.dwe  = 1'b0;
        nxt_d.xwe  = 1'b0;
        nxt_d.ywe  = 1'b0;
        div_load_d = 1'b0;
        mul_load_d = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.st = ST_SETUP;
                    nxt_d.op = wau_op_e'(op);
                    nxt_d.d  = d_in;
                    nxt_d.x  = x_in;
                    nxt_d.y  = y_in;
                end
            end
            ST_SETUP: begin
                div_load_d = is_div_d;
                mul_load_d = !is_div_d;
                nxt_d.st   = ST_WAIT;
            end
            ST_WAIT: begin
                if (is_div_d && div_vld) begin
                    nxt_d.st   = ST_IDLE;
                    nxt_d.done = 1'b1;
                    nxt_d.dout = cur_q.d;
                    nxt_d.xout = cur_q.x;
                    nxt_d.yout = cur_q.y;
                    if (cur_q.x == '0) begin
                        nxt_d.flags = 4'b0001;
                        nxt_d.mask  = 4'b0001;
                    end else begin
                        nxt_d.dout = rem_s_d;
                        nxt_d.dwe  = 1'b1;
                        if (cur_q.op == OP_SDIV16) begin
                            nxt_d.xout = quo_lo_d;
                            nxt_d.xwe  = 1'b1;
                        end else begin
                            nxt_d.yout = quo_lo_d;
                            nxt_d.ywe  = 1'b1;
                        end
                        nxt_d.flags[FLG_N] = quo_lo_d[W-1];
                        nxt_d.flags[FLG_Z] = div_quo == '0;
                        nxt_d.flags[FLG_V] = div_ovf_d;
                        nxt_d.flags[FLG_C] = 1'b0;
                        nxt_d.mask         = 4'b1111;
                    end
                end else if (!is_div_d && mul_vld) begin
                    nxt_d.st   = ST_IDLE;
                    nxt_d.done = 1'b1;
                    nxt_d.xout = cur_q.x;
                    nxt_d.dout = prod_s_d[W-1:0];
                    nxt_d.yout = prod_s_d[W2-1:W];
                    nxt_d.dwe  = 1'b1;
                    nxt_d.ywe  = 1'b1;
                    nxt_d.flags[FLG_N] = prod_s_d[W2-1];
                    nxt_d.flags[FLG_Z] = prod_s_d == '0;
                    nxt_d.flags[FLG_V] = 1'b0;
                    nxt_d.flags[FLG_C] = prod_s_d[W-1];
                    nxt_d.mask         = 4'b1101;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    wau_div_core #(.NUM_W(W2), .DEN_W(W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (div_load_d),
        .num   (dvd_mag_d),
        .den   (dvs_mag_d),
        .quo   (div_quo),
        .rem   (div_rem),
        .valid (div_vld)
    );

    wau_mul_core #(.W(W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mul_load_d),
        .a     (ma_mag_d),
        .b     (mb_mag_d),
        .prod  (mul_prod),
        .valid (mul_vld)
    );

    assign busy      = cur_q.st != ST_IDLE;
    assign done      = cur_q.done;
    assign d_out     = cur_q.dout;
    assign x_out     = cur_q.xout;
    assign y_out     = cur_q.yout;
    assign d_we      = cur_q.dwe;
    assign x_we      = cur_q.xwe;
    assign y_we      = cur_q.ywe;
    assign flag_n    = cur_q.flags[FLG_N];
    assign flag_z    = cur_q.flags[FLG_Z];
    assign flag_v    = cur_q.flags[FLG_V];
    assign flag_c    = cur_q.flags[FLG_C];
    assign flag_mask = cur_q.mask;

endmodule

// File: rtl/wau_checker.sv
module wau_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic [W-1:0] x_in,
    input logic         busy,
    input logic         done,
    input logic         d_we,
    input logic         x_we,
    input logic         y_we,
    input logic         flag_c,
    input logic [3:0]   flag_mask
);
    localparam int DIV_LAT = 2 * W + 3;
    localparam int MUL_LAT = W + 3;

    logic [1:0]   op_cap_q;
    logic [W-1:0] x_cap_q;
    logic [15:0]  lat_q;
    logic         accept;
    logic         cap_mul;

    assign accept  = start && !busy;
    assign cap_mul = op_cap_q == 2'd3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_cap_q <= '0;
            x_cap_q  <= '0;
            lat_q    <= '0;
        end else if (accept) begin
            op_cap_q <= op;
            x_cap_q  <= x_in;
            lat_q    <= 16'd1;
        end else if (busy) begin
            lat_q    <= lat_q + 16'd1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == (cap_mul ? 16'(MUL_LAT) : 16'(DIV_LAT)))); // R8

    AST_WE_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (d_we || x_we || y_we) |-> done); // R10

    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_mul && x_cap_q == '0) |->
            (flag_c && !d_we && !x_we && !y_we && flag_mask == 4'b0001)); // R5

    AST_DIV_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cap_mul && x_cap_q != '0) |->
            (!flag_c && flag_mask == 4'b1111 && d_we)); // R6

    AST_MUL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_mul) |-> (flag_mask == 4'b1101 && d_we && y_we && !x_we)); // R7

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (busy && !done)); // R9

endmodule

bind wide_arith_unit wau_checker #(.W(W)) u_wau_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .x_in      (x_in),
    .busy      (busy),
    .done      (done),
    .d_we      (d_we),
    .x_we      (x_we),
    .y_we      (y_we),
    .flag_c    (flag_c),
    .flag_mask (flag_mask)
);

// File: tb/wide_arith_unit_bench.sv
`timescale 1ns/1ps
module wide_arith_unit_bench;
    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  op;
    logic [15:0] d_in, x_in, y_in;
    logic        busy, done;
    logic [15:0] d_out, x_out, y_out;
    logic        d_we, x_we, y_we;
    logic        flag_n, flag_z, flag_v, flag_c;
    logic [3:0]  flag_mask;

    always #2 clk = ~clk;   // 250 MHz

    wide_arith_unit #(.W(W)) u_wide_arith_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .d_in(d_in), .x_in(x_in), .y_in(y_in),
        .busy(busy), .done(done),
        .d_out(d_out), .x_out(x_out), .y_out(y_out),
        .d_we(d_we), .x_we(x_we), .y_we(y_we),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
        .flag_mask(flag_mask)
    );

    typedef struct packed {
        logic [31:0] due;
        logic        dwe, xwe, ywe;
        logic [15:0] dv, xv, yv;
        logic [3:0]  mask;
        logic [3:0]  flags;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    int    checks = 0;
    int    fails  = 0;
    int    cyc    = 0;
    bit    finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [1:0] o, input logic [15:0] d,
                                   input logic [15:0] x, input logic [15:0] y);
        exp_t   e;
        longint a, b, q, r, p;
        e = '0;
        e.dv = d; e.xv = x; e.yv = y;
        if (o == 2'd3) begin
            p = longint'($signed(d)) * longint'($signed(y));
            e.dv = p[15:0]; e.yv = p[31:16];
            e.dwe = 1'b1; e.ywe = 1'b1;
            e.flags = {p[31], p[31:0] == 32'd0, 1'b0, p[15]};
            e.mask  = 4'b1101;
        end else if (x == 16'd0) begin
            e.flags = 4'b0001;
            e.mask  = 4'b0001;
        end else begin
            if (o == 2'd0) begin
                a = longint'($signed(d));
                b = longint'($signed(x));
            end else if (o == 2'd1) begin
                a = {32'd0, y, d};
                b = {48'd0, x};
            end else begin
                a = longint'($signed({y, d}));
                b = longint'($signed(x));
            end
            q = a / b;
            r = a % b;
            e.dv  = r[15:0];
            e.dwe = 1'b1;
            if (o == 2'd0) begin e.xv = q[15:0]; e.xwe = 1'b1; end
            else           begin e.yv = q[15:0]; e.ywe = 1'b1; end
            e.flags[3] = q[15];
            e.flags[2] = (q == 0);
            e.flags[1] = (o == 2'd1) ? (q > 65535) : (q > 32767 || q < -32768);
            e.flags[0] = 1'b0;
            e.mask = 4'b1111;
        end
        return e;
    endfunction

    function automatic string req_of(input logic [1:0] o, input logic [15:0] x);
        if (o == 2'd3) return "R4/R7";
        if (x == 16'd0) return "R5";
        if (o == 2'd0) return "R1/R6";
        if (o == 2'd1) return "R2/R6";
        return "R3/R6";
    endfunction

    task automatic push_exp(input logic [1:0] o, input logic [15:0] d,
                            input logic [15:0] x, input logic [15:0] y);
        exp_t e;
        e = model(o, d, x, y);
        e.due = 32'(cyc + ((o == 2'd3) ? (W + 3) : (2 * W + 3)));
        exp_q.push_back(e);
        req_q.push_back(req_of(o, x));
    endtask

    // issue one operation at a falling edge and wait for the done cycle
    task automatic issue(input logic [1:0] o, input logic [15:0] d,
                         input logic [15:0] x, input logic [15:0] y);
        push_exp(o, d, x, y);
        start = 1'b1; op = o; d_in = d; x_in = x; y_in = y;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    // same, with an intruding start while busy (R9)
    task automatic issue_intrude(input logic [1:0] o, input logic [15:0] d,
                                 input logic [15:0] x, input logic [15:0] y);
        push_exp(o, d, x, y);
        start = 1'b1; op = o; d_in = d; x_in = x; y_in = y;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1; op = ~o; d_in = ~d; x_in = 16'd0; y_in = ~y;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected done", 1, 0);
            end else begin
                exp_t  e;
                string rq;
                e  = exp_q.pop_front();
                rq = req_q.pop_front();
                chk(cyc == int'(e.due), {rq, " R8"}, "done cycle", cyc, e.due);
                chk({d_we, x_we, y_we} == {e.dwe, e.xwe, e.ywe}, {rq, " R10"}, "write enables",
                    {d_we, x_we, y_we}, {e.dwe, e.xwe, e.ywe});
                chk(d_out == e.dv, rq, "d_out", d_out, e.dv);
                chk(x_out == e.xv, rq, "x_out", x_out, e.xv);
                chk(y_out == e.yv, rq, "y_out", y_out, e.yv);
                chk(flag_mask == e.mask, rq, "flag_mask", flag_mask, e.mask);
                chk(({flag_n, flag_z, flag_v, flag_c} & e.mask) == (e.flags & e.mask), rq, "flags",
                    {flag_n, flag_z, flag_v, flag_c} & e.mask, e.flags & e.mask);
            end
        end
        if (rst_n && !done)
            chk(!(d_we || x_we || y_we), "R10", "write enable outside done", {d_we, x_we, y_we}, 0);
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; op = '0; d_in = '0; x_in = '0; y_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(!busy, "R10", "busy after reset", busy, 0);
        chk(!done, "R10", "done after reset", done, 0);

        // R1 signed 16/16
        issue(2'd0, 16'd100, 16'd7, 16'h5A5A);
        issue(2'd0, -16'sd100, 16'd7, 16'h1111);
        issue(2'd0, 16'd100, -16'sd7, 16'h2222);
        issue(2'd0, 16'h8000, 16'hFFFF, 16'h3333);   // R6 overflow
        issue(2'd0, 16'd5, 16'd10, 16'h4444);        // R6 zero quotient
        issue(2'd0, 16'h8000, 16'd1, 16'h0);         // R6 N set
        issue(2'd0, 16'd77, 16'd0, 16'h7777);        // R5
        // R2 unsigned 32/16
        issue(2'd1, 16'h0000, 16'd2, 16'h0001);
        issue(2'd1, 16'h5678, 16'h0010, 16'h1234);   // R6 overflow
        issue(2'd1, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        issue(2'd1, 16'd2, 16'd3, 16'd2);
        issue(2'd1, 16'd1000, 16'd0, 16'd0);         // R5
        // R3 signed 32/16
        issue(2'd2, 16'hBDC0, 16'd1000, 16'hFFF0);   // -1000000/1000
        issue(2'd2, 16'h0000, 16'hFFFF, 16'h8000);   // R6 overflow
        issue(2'd2, 16'd7, -16'sd2, 16'd0);
        issue(2'd2, -16'sd7, 16'd2, 16'hFFFF);
        issue(2'd2, 16'd9, 16'd0, 16'hFFFF);         // R5
        // R4 multiply
        issue(2'd3, 16'd300, 16'h1234, 16'd200);     // R7 C set
        issue(2'd3, -16'sd3, 16'd0, 16'd5);
        issue(2'd3, 16'h8000, 16'd0, 16'h8000);
        issue(2'd3, 16'd0, 16'd9, -16'sd5);          // R7 Z set
        issue(2'd3, 16'd123, 16'd1, 16'hFFFF);

        // R9: starts while busy are ignored
        issue_intrude(2'd0, 16'd1234, 16'd11, 16'd0);
        issue_intrude(2'd3, 16'd55, 16'd0, -16'sd66);

        for (int i = 0; i < 24; i++) begin
            logic [15:0] rd, rx, ry;
            rd = 16'($urandom);
            rx = 16'($urandom);
            ry = 16'($urandom);
            if (i % 3 == 0) ry = {16{rd[15]}};
            if (i % 5 == 0) rx = {8'd0, rx[7:0]};
            issue(2'(i % 4), rd, rx, ry);
        end

        repeat (80) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "pending results", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule